// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds the single reservation of one hart. A load-linked request records its address and opens a link over an aligned block of memory, called the granule. The granule is 32 or 64 bytes, picked by an input. The link breaks in two cases: another agent writes anywhere in the granule, seen on the snoop port, or the cache reports that the reserved line was evicted or missed.

A later store-conditional is judged against the link. It passes only when the link is intact and the store falls in the reserved granule. On a pass the block issues the store. On a fail no store goes out, and the block returns a full-width result whose nonzero value names the cause.

Failed store-conditionals are counted. Once a set number of consecutive failures is reached, a flag tells the core to issue its next load-linked as a locking load. That reservation cannot be broken, so the retry loop in software is certain to finish. The locked mode ends when the store-conditional that follows the locked load completes.

Top module: `resmon_top`

## Requirements
- R1: A store-conditional request (`sc_valid` high for one cycle) gives `sc_done` high in the next cycle, together with `sc_result` and `sc_store`. When no request was made in the previous cycle, `sc_done` is low. A result of 0 means pass, and `sc_store` is high exactly when the result is 0. A store-conditional in the granule of an intact link passes.
- R2: Granule matching compares addresses with their low bits dropped. With `big_granule`=0, bits [4:0] are dropped (32 bytes). With `big_granule`=1, bits [5:0] are dropped (64 bytes).
- R3: A snoop write (`snoop_valid`) whose address is in the reserved granule breaks the link. A later store-conditional then fails with result 1. Snoops outside the granule have no effect.
- R4: An eviction or miss notice (`evict_valid`) in the reserved granule breaks the link. A later store-conditional then fails with result 2. If a snoop and an eviction break the link in the same cycle, the result is 1.
- R5: A store-conditional with no reservation held fails with result 3. If a link is held and intact but the store address is outside its granule, the result is 4. The causes are ranked in this order: no reservation, then a break recorded earlier, then a snoop in the same cycle, then an eviction in the same cycle, then address mismatch.
- R6: Every store-conditional, passed or failed, clears the reservation. A load-linked replaces any reservation already held. When a load-linked and a store-conditional arrive together, the store-conditional is judged against the old reservation and the load-linked then sets up the new one.
- R7: When a snoop write to the reserved granule arrives in the same cycle as a store-conditional, the snoop wins and the result is 1.
- R8: Each failed store-conditional adds one to a failure count, which stops at FAIL_LIMIT (default 3). A passing one resets the count to 0. `force_locked` is high exactly while the count equals FAIL_LIMIT.
- R9: A load-linked accepted while `force_locked` is high makes a locked reservation, which snoops and evictions cannot break. The store-conditional that completes this reservation resets the count to 0, whatever its result.
- R10: After reset no reservation is held, the count is 0, and `sc_done`, `sc_store` and `force_locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_granule | input | 1 | 0: 32-byte granule, 1: 64-byte granule |
| ll_valid | input | 1 | Load-linked request |
| ll_addr | input | ADDR_W | Load-linked address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional address |
| snoop_valid | input | 1 | Write seen from another agent |
| snoop_addr | input | ADDR_W | Address of the snooped write |
| evict_valid | input | 1 | Line eviction or miss notice |
| evict_addr | input | ADDR_W | Address of the evicted or missed line |
| sc_done | output | 1 | Store-conditional result valid |
| sc_result | output | RES_W | 0 = pass, otherwise the failure cause |
| sc_store | output | 1 | Store issued for the store-conditional |
| force_locked | output | 1 | Issue the next load-linked as a locking load |

## Verification
A snoop write and a store-conditional can land in the same cycle on the reserved granule. This race is the main concern. The bench provokes it by driving both requests on one clock edge, sweeping the snoop offset across and past the granule in both granule sizes. It also repeats the race with an eviction in place of the snoop, and with the reservation locked. Each outcome is judged against a reference model kept in the bench. For an unlocked link, a hit must give result 1 with no store issued. A locked link must ignore the snoop, and a snoop outside the granule must leave the store-conditional passing.

// File: rtl/resmon_pkg.sv
package resmon_pkg;

    localparam int MAX_AW   = 64;
    localparam int LO_SMALL = 5;   // 32-byte granule
    localparam int LO_BIG   = 6;   // 64-byte granule

    typedef enum logic [2:0] {
        CZ_PASS     = 3'd0,
        CZ_SNOOP    = 3'd1,
        CZ_EVICT    = 3'd2,
        CZ_NOLINK   = 3'd3,
        CZ_MISMATCH = 3'd4
    } sc_cause_e;

    typedef struct packed {
        logic      held;
        logic      locked;
        sc_cause_e brk;
    } link_state_t;

    function automatic logic gran_hit(input logic [MAX_AW-1:0] a,
                                      input logic [MAX_AW-1:0] b,
                                      input logic big);
        int sh;
        sh = big ? LO_BIG : LO_SMALL;
        return (a >> sh) == (b >> sh);
    endfunction

endpackage

// File: rtl/resmon_link.sv
module resmon_link
    import resmon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_granule,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              ll_lock,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    output sc_cause_e         sc_cause,
    output logic              link_held,
    output logic              link_locked
);

    link_state_t       st;
    logic [ADDR_W-1:0] res_addr;
    logic              sn_hit, ev_hit, sc_in;

    always_comb begin
        sn_hit = snoop_valid && st.held && !st.locked &&
                 gran_hit(MAX_AW'(snoop_addr), MAX_AW'(res_addr), big_granule);
        ev_hit = evict_valid && st.held && !st.locked &&
                 gran_hit(MAX_AW'(evict_addr), MAX_AW'(res_addr), big_granule);
        sc_in  = gran_hit(MAX_AW'(sc_addr), MAX_AW'(res_addr), big_granule);
    end

    always_comb begin
        if (!st.held)              sc_cause = CZ_NOLINK;
        else if (st.brk != CZ_PASS) sc_cause = st.brk;
        else if (sn_hit)           sc_cause = CZ_SNOOP;
        else if (ev_hit)           sc_cause = CZ_EVICT;
        else if (!sc_in)           sc_cause = CZ_MISMATCH;
        else                       sc_cause = CZ_PASS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '{held: 1'b0, locked: 1'b0, brk: CZ_PASS};
            res_addr <= '0;
        end else if (ll_valid) begin
            st       <= '{held: 1'b1, locked: ll_lock, brk: CZ_PASS};
            res_addr <= ll_addr;
        end else if (sc_valid) begin
            st       <= '{held: 1'b0, locked: 1'b0, brk: CZ_PASS};
        end else if (st.brk == CZ_PASS) begin
            if (sn_hit)      st.brk <= CZ_SNOOP;
            else if (ev_hit) st.brk <= CZ_EVICT;
        end
    end

    assign link_held   = st.held;
    assign link_locked = st.locked;

    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sc_valid && !ll_valid |=> !link_held); // R6

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        link_held && link_locked && !sc_valid && !ll_valid |=>
        link_held && st.brk == CZ_PASS); // R9

    AST_LL_OPENS: assert property (@(posedge clk) disable iff (rst)
        ll_valid |=> link_held && st.brk == CZ_PASS); // R6

endmodule

// File: rtl/resmon_escalate.sv
module resmon_escalate
    import resmon_pkg::*;
#(
    parameter int FAIL_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sc_valid,
    input  logic sc_pass,
    input  logic link_locked,
    output logic force_locked
);

    localparam int CNT_W = $clog2(FAIL_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FAIL_LIMIT);

    logic [CNT_W-1:0] fails;

    always_ff @(posedge clk) begin
        if (rst) begin
            fails <= '0;
        end else if (sc_valid) begin
            if (sc_pass || link_locked) fails <= '0;
            else if (fails != LIMIT)    fails <= fails + 1'b1;
        end
    end

    assign force_locked = (fails == LIMIT);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fails <= LIMIT); // R8

    AST_PASS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sc_valid && sc_pass |=> fails == '0); // R8

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        sc_valid && link_locked |=> !force_locked); // R9

endmodule

// File: rtl/resmon_top.sv
module resmon_top
    import resmon_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RES_W      = 32,
    parameter int FAIL_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_granule,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    output logic              sc_done,
    output logic [RES_W-1:0]  sc_result,
    output logic              sc_store,
    output logic              force_locked
);

    sc_cause_e cause;
    logic      held, locked;

    resmon_link #(.ADDR_W(ADDR_W)) u_link (
        .clk         (clk),
        .rst         (rst),
        .big_granule (big_granule),
        .ll_valid    (ll_valid),
        .ll_addr     (ll_addr),
        .ll_lock     (force_locked),
        .sc_valid    (sc_valid),
        .sc_addr     (sc_addr),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .evict_valid (evict_valid),
        .evict_addr  (evict_addr),
        .sc_cause    (cause),
        .link_held   (held),
        .link_locked (locked)
    );

    resmon_escalate #(.FAIL_LIMIT(FAIL_LIMIT)) u_esc (
        .clk          (clk),
        .rst          (rst),
        .sc_valid     (sc_valid),
        .sc_pass      (cause == CZ_PASS),
        .link_locked  (locked),
        .force_locked (force_locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_done   <= 1'b0;
            sc_result <= '0;
            sc_store  <= 1'b0;
        end else begin
            sc_done   <= sc_valid;
            sc_result <= sc_valid ? RES_W'(cause) : '0;
            sc_store  <= sc_valid && (cause == CZ_PASS);
        end
    end

    AST_STORE_MATCH: assert property (@(posedge clk) disable iff (rst)
        sc_done |-> (sc_store == (sc_result == '0))); // R1

    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
        !sc_valid |=> !sc_done && !sc_store); // R1

    AST_NOLINK_CODE: assert property (@(posedge clk) disable iff (rst)
        sc_valid && !held |=> sc_done && sc_result == RES_W'(3)); // R5

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        sc_done |-> sc_result <= RES_W'(4)); // R5

endmodule

// File: tb/sim_resmon_top.sv
module sim_resmon_top;

    localparam int AW = 32;
    localparam int RW = 32;
    localparam int LIM = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          big_granule = 1'b0;
    logic          ll_valid = 1'b0, sc_valid = 1'b0;
    logic          snoop_valid = 1'b0, evict_valid = 1'b0;
    logic [AW-1:0] ll_addr = '0, sc_addr = '0, snoop_addr = '0, evict_addr = '0;
    logic          sc_done, sc_store, force_locked;
    logic [RW-1:0] sc_result;

    int errors = 0;
    int checks = 0;

    // bench reference state
    bit          m_held = 0, m_locked = 0;
    int          m_brk = 0, m_cnt = 0;
    logic [AW-1:0] m_addr = '0;

    always #2 clk = ~clk;

    resmon_top #(.ADDR_W(AW), .RES_W(RW), .FAIL_LIMIT(LIM)) u0 (
        .clk(clk), .rst(rst), .big_granule(big_granule),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .sc_done(sc_done), .sc_result(sc_result),
        .sc_store(sc_store), .force_locked(force_locked)
    );

    function automatic bit same_gran(logic [AW-1:0] a, logic [AW-1:0] b);
        int sh = big_granule ? 6 : 5;
        return (a >> sh) == (b >> sh);
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus, then compare against the reference.
    task automatic step(string tag, bit ll, logic [AW-1:0] lla,
                        bit sc, logic [AW-1:0] sca,
                        bit sn, logic [AW-1:0] sna,
                        bit ev, logic [AW-1:0] eva);
        bit hs, he, fl_old;
        int cz;
        @(negedge clk);
        ll_valid = ll; ll_addr = lla; sc_valid = sc; sc_addr = sca;
        snoop_valid = sn; snoop_addr = sna; evict_valid = ev; evict_addr = eva;
        hs = sn && m_held && !m_locked && same_gran(sna, m_addr);
        he = ev && m_held && !m_locked && same_gran(eva, m_addr);
        fl_old = (m_cnt == LIM);
        cz = 0;
        if (sc) begin
            if (!m_held)                  cz = 3;
            else if (m_brk != 0)          cz = m_brk;
            else if (hs)                  cz = 1;
            else if (he)                  cz = 2;
            else if (!same_gran(sca, m_addr)) cz = 4;
            if (cz == 0 || m_locked) m_cnt = 0;
            else if (m_cnt < LIM)    m_cnt++;
        end
        if (ll) begin
            m_held = 1; m_addr = lla; m_brk = 0; m_locked = fl_old;
        end else if (sc) begin
            m_held = 0; m_brk = 0; m_locked = 0;
        end else if (m_brk == 0) begin
            if (hs) m_brk = 1;
            else if (he) m_brk = 2;
        end
        @(negedge clk);
        ll_valid = 0; sc_valid = 0; snoop_valid = 0; evict_valid = 0;
        check(tag, "sc_done", sc_done, sc);
        check(tag, "sc_result", sc_result, cz);
        check(tag, "sc_store", sc_store, sc && cz == 0);
        check(tag, "force_locked", force_locked, m_cnt == LIM);
    endtask

    task automatic idle_ll(string tag, logic [AW-1:0] a);
        step(tag, 1, a, 0, '0, 0, '0, 0, '0);
    endtask

    task automatic sc_only(string tag, logic [AW-1:0] a);
        step(tag, 0, '0, 1, a, 0, '0, 0, '0);
    endtask

    task automatic pass_once(logic [AW-1:0] a);
        // clears the count by passing (or by a locked completion)
        idle_ll("R8", a);
        sc_only("R8", a);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        check("R10", "sc_done", sc_done, 0);
        check("R10", "sc_store", sc_store, 0);
        check("R10", "force_locked", force_locked, 0);
        sc_only("R10", 32'h40);          // nothing held after reset: code 3
        pass_once(32'h80);               // R1 basic pass

        // R2 / R5 granule sweep in both sizes
        for (int g = 0; g < 2; g++) begin
            big_granule = g[0];
            for (int lo = 0; lo < 64; lo += 12) begin
                for (int so = 0; so < 160; so += 8) begin
                    base = 32'h1000;
                    idle_ll("R2", base + AW'(lo));
                    sc_only("R2", base + AW'(so));
                end
            end
        end

        // R3 / R7 snoop before and in the same cycle as SC; R4 eviction
        for (int g = 0; g < 2; g++) begin
            big_granule = g[0];
            for (int so = 0; so < 128; so += 4) begin
                base = 32'h2000;
                if (force_locked) pass_once(base);
                idle_ll("R3", base);
                step("R3", 0, '0, 0, '0, 1, base + AW'(so), 0, '0);
                sc_only("R3", base + 4);
                if (force_locked) pass_once(base);
                idle_ll("R7", base);
                step("R7", 0, '0, 1, base + 8, 1, base + AW'(so), 0, '0);
                if (force_locked) pass_once(base);
                idle_ll("R4", base);
                step("R4", 0, '0, 0, '0, 0, '0, 1, base + AW'(so));
                sc_only("R4", base);
                if (force_locked) pass_once(base);
                idle_ll("R4", base);
                step("R4", 0, '0, 0, '0, 1, base + AW'(so), 1, base + AW'(so));
                sc_only("R4", base);
                if (force_locked) pass_once(base);
                idle_ll("R4", base);
                step("R4", 0, '0, 1, base, 0, '0, 1, base + AW'(so));
            end
        end

        // R6 LL replaces, SC clears, LL+SC together
        big_granule = 0;
        pass_once(32'h3000);
        idle_ll("R6", 32'h3000);
        idle_ll("R6", 32'h3400);
        sc_only("R6", 32'h3000);         // mismatch with replaced link
        idle_ll("R6", 32'h3400);
        sc_only("R6", 32'h3400);
        sc_only("R6", 32'h3400);         // cleared: code 3
        idle_ll("R6", 32'h3800);
        step("R6", 1, 32'h3900, 1, 32'h3800, 0, '0, 0, '0);
        sc_only("R6", 32'h3900);

        // R8 / R9 escalation, locked link immune, release
        pass_once(32'h5000);
        for (int k = 0; k < LIM + 2; k++) sc_only("R8", 32'h5000);
        idle_ll("R9", 32'h5000);         // locked load
        step("R9", 0, '0, 0, '0, 1, 32'h5004, 1, 32'h5008);
        step("R9", 0, '0, 1, 32'h5010, 1, 32'h5000, 0, '0);
        for (int k = 0; k < LIM; k++) sc_only("R9", 32'h5000);
        idle_ll("R9", 32'h6000);
        sc_only("R9", 32'h7000);         // locked, mismatch, still releases
        idle_ll("R9", 32'h6000);
        step("R9", 0, '0, 0, '0, 1, 32'h6000, 0, '0);
        sc_only("R9", 32'h6000);         // unlocked again: snoop broke it

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule